// File: doc/BRIEF.md
# Serial Control Register Port

This block receives 16-bit control words over a three-wire serial link (serial clock, serial data and a latch strobe) and loads a 14-bit payload into one of three registers: left volume, right volume or control. The three serial inputs are asynchronous to the system clock. They are synchronized into the system clock domain and edge-detected there. All shifting and counting runs on the system clock.

The sender shifts a word in most significant bit first and changes the data while the serial clock is low. The block samples each bit when it detects a rising edge of the serial clock. After the sixteenth bit, a rising edge on the latch strobe commits the word. The two lowest bits of the word pick the target register, and the upper fourteen bits become its new value. Each register has its own write strobe, which is high for one system clock cycle in the cycle where the new value appears.

Top module: `serial_ctrl_port`

## Requirements
- R1: Each bit is taken from the data line at a detected rising edge of the serial clock. The first bit sampled is word bit 15 and the sixteenth is word bit 0.
- R2: Select code bits[1:0] = 2'b00 writes word bits[15:2] into the left volume register.
- R3: Select code bits[1:0] = 2'b10 writes word bits[15:2] into the right volume register.
- R4: Select code bits[1:0] = 2'b01 writes word bits[15:2] into the control register.
- R5: Select code bits[1:0] = 2'b11 writes nothing: no register value changes and no write strobe pulses.
- R6: Registers change only after a rising edge of the latch strobe. A complete 16-bit word that has been shifted in but not yet latched leaves every register unchanged.
- R7: If the latch strobe rises after any bit count other than 16, including 0, 15 and 17 bits, the frame is dropped and no register changes.
- R8: Every rising edge of the latch strobe clears the bit counter, so a correct frame after a dropped frame is accepted.
- R9: When a register takes a new value, its own write strobe is high for exactly one system clock cycle, in the same cycle the new value appears. The other strobes stay low.
- R10: Synchronous active-high reset clears all three registers and all write strobes to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk_i | input | 1 | Serial clock, asynchronous |
| ser_data_i | input | 1 | Serial data, MSB first, asynchronous |
| ser_latch_i | input | 1 | Latch strobe, rising edge commits the word |
| vol_left_o | output | 14 | Left volume register |
| vol_right_o | output | 14 | Right volume register |
| ctrl_o | output | 14 | Control register |
| wr_left_o | output | 1 | One-cycle write strobe, left volume |
| wr_right_o | output | 1 | One-cycle write strobe, right volume |
| wr_ctrl_o | output | 1 | One-cycle write strobe, control |

## Verification
The assertions assume that every serial clock phase, every latch phase, and the data setup and hold around each serial clock rise last several system clock cycles. Under that assumption, each edge passes through the synchronizers exactly once, and the data bit is already stable when its clock edge is detected. The stimulus holds each phase for at least two system clocks and changes the data only while the serial clock is low. This mirrors the minimum pulse widths of a slow serial link feeding a fast system clock. Under these conditions a commit must come from a latch edge seen after exactly sixteen counted bits, and the register outputs must stay constant between write strobes.

// File: rtl/scp_pkg.sv
package scp_pkg;
  typedef enum logic [1:0] {
    SEL_LEFT  = 2'b00,
    SEL_CTRL  = 2'b01,
    SEL_RIGHT = 2'b10,
    SEL_NONE  = 2'b11
  } sel_e;

  localparam int NUM_TARGETS = 3;

  function automatic logic [1:0] target_code(input int idx);
    case (idx)
      0:       target_code = SEL_LEFT;
      1:       target_code = SEL_RIGHT;
      default: target_code = SEL_CTRL;
    endcase
  endfunction
endpackage

// File: rtl/scp_sync.sv
module scp_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] level_o,
  output logic [WIDTH-1:0] rise_o
);
  genvar g;
  generate
    for (g = 0; g < WIDTH; g++) begin : g_bit
      logic [STAGES-1:0] chain;
      logic              prev;
      always_ff @(posedge clk) begin
        if (rst) begin
          chain <= '0;
          prev  <= 1'b0;
        end else begin
          chain <= {chain[STAGES-2:0], async_i[g]};
          prev  <= chain[STAGES-1];
        end
      end
      assign level_o[g] = chain[STAGES-1];
      assign rise_o[g]  = chain[STAGES-1] & ~prev;
    end
  endgenerate
endmodule

// File: rtl/scp_shifter.sv
module scp_shifter #(
  parameter int WORD_W = 16,
  parameter int CNT_W  = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              shift_en_i,
  input  logic              bit_i,
  input  logic              frame_end_i,
  output logic [WORD_W-1:0] word_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              frame_ok_o
);
  localparam logic [CNT_W-1:0] CNT_MAX  = '1;
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(WORD_W);

  logic [WORD_W-1:0] sreg;
  logic [CNT_W-1:0]  cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      sreg <= '0;
    end else if (shift_en_i) begin
      sreg <= {sreg[WORD_W-2:0], bit_i};
    end
  end

  always_ff @(posedge clk) begin
    if (rst || frame_end_i) begin
      cnt <= '0;
    end else if (shift_en_i && cnt != CNT_MAX) begin
      cnt <= cnt + 1'b1;
    end
  end

  assign word_o     = sreg;
  assign cnt_o      = cnt;
  assign frame_ok_o = frame_end_i && (cnt == CNT_FULL);
endmodule

// File: rtl/scp_regfile.sv
module scp_regfile
  import scp_pkg::*;
#(
  parameter int DATA_W = 14,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              commit_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] regs_o [NUM_TARGETS],
  output logic [NUM_TARGETS-1:0] wr_o
);
  logic [NUM_TARGETS-1:0] hit;

  genvar g;
  generate
    for (g = 0; g < NUM_TARGETS; g++) begin : g_reg
      localparam logic [ADDR_W-1:0] CODE = ADDR_W'(target_code(g));
      assign hit[g] = commit_i && (addr_i == CODE);
      always_ff @(posedge clk) begin
        if (rst) begin
          regs_o[g] <= '0;
          wr_o[g]   <= 1'b0;
        end else begin
          wr_o[g] <= hit[g];
          if (hit[g]) regs_o[g] <= data_i;
        end
      end
    end
  endgenerate
endmodule

// File: rtl/serial_ctrl_port.sv
module serial_ctrl_port
  import scp_pkg::*;
#(
  parameter int WORD_W      = 16,
  parameter int ADDR_W      = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     ser_clk_i,
  input  logic                     ser_data_i,
  input  logic                     ser_latch_i,
  output logic [WORD_W-ADDR_W-1:0] vol_left_o,
  output logic [WORD_W-ADDR_W-1:0] vol_right_o,
  output logic [WORD_W-ADDR_W-1:0] ctrl_o,
  output logic                     wr_left_o,
  output logic                     wr_right_o,
  output logic                     wr_ctrl_o
);
  localparam int DATA_W = WORD_W - ADDR_W;
  localparam int CNT_W  = $clog2(WORD_W) + 2;
  localparam int IDX_CLK = 0, IDX_DAT = 1, IDX_LAT = 2;

  logic [2:0]              lvl, rise;
  logic                    sclk_rise, latch_rise, sdata_lvl;
  logic [WORD_W-1:0]       word;
  logic [CNT_W-1:0]        bit_cnt;
  logic                    frame_ok;
  logic [DATA_W-1:0]       regs [NUM_TARGETS];
  logic [NUM_TARGETS-1:0]  wr;

  scp_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst),
    .async_i({ser_latch_i, ser_data_i, ser_clk_i}),
    .level_o(lvl), .rise_o(rise)
  );

  assign sclk_rise  = rise[IDX_CLK];
  assign sdata_lvl  = lvl[IDX_DAT];
  assign latch_rise = rise[IDX_LAT];

  scp_shifter #(.WORD_W(WORD_W), .CNT_W(CNT_W)) u_shift (
    .clk(clk), .rst(rst),
    .shift_en_i(sclk_rise), .bit_i(sdata_lvl), .frame_end_i(latch_rise),
    .word_o(word), .cnt_o(bit_cnt), .frame_ok_o(frame_ok)
  );

  scp_regfile #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst),
    .commit_i(frame_ok), .addr_i(word[ADDR_W-1:0]), .data_i(word[WORD_W-1:ADDR_W]),
    .regs_o(regs), .wr_o(wr)
  );

  assign vol_left_o  = regs[0];
  assign vol_right_o = regs[1];
  assign ctrl_o      = regs[2];
  assign wr_left_o   = wr[0];
  assign wr_right_o  = wr[1];
  assign wr_ctrl_o   = wr[2];
endmodule

// File: rtl/scp_checker.sv
module scp_checker #(
  parameter int DATA_W = 14,
  parameter int CNT_W  = 6,
  parameter int WORD_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              latch_rise,
  input logic [CNT_W-1:0]  bit_cnt,
  input logic [DATA_W-1:0] vol_left_o,
  input logic [DATA_W-1:0] vol_right_o,
  input logic [DATA_W-1:0] ctrl_o,
  input logic              wr_left_o,
  input logic              wr_right_o,
  input logic              wr_ctrl_o
);
  logic any_wr;
  assign any_wr = wr_left_o | wr_right_o | wr_ctrl_o;

  AST_ONE_TARGET: assert property (@(posedge clk) disable iff (rst)
    $onehot0({wr_left_o, wr_right_o, wr_ctrl_o})); // R9

  AST_STROBE_SHORT: assert property (@(posedge clk) disable iff (rst)
    any_wr |=> !any_wr); // R9

  AST_AFTER_LATCH: assert property (@(posedge clk) disable iff (rst)
    any_wr |-> $past(latch_rise)); // R6

  AST_FULL_FRAME: assert property (@(posedge clk) disable iff (rst)
    any_wr |-> $past(bit_cnt) == CNT_W'(WORD_W)); // R7

  AST_LEFT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !wr_left_o |-> $stable(vol_left_o)); // R2

  AST_RIGHT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !wr_right_o |-> $stable(vol_right_o)); // R3

  AST_CTRL_HOLD: assert property (@(posedge clk) disable iff (rst)
    !wr_ctrl_o |-> $stable(ctrl_o)); // R4

  AST_RESET_CLEAR: assert property (@(posedge clk)
    $past(rst) |-> (vol_left_o == '0 && vol_right_o == '0 && ctrl_o == '0 && !any_wr)); // R10
endmodule

bind serial_ctrl_port scp_checker #(.DATA_W(DATA_W), .CNT_W(CNT_W), .WORD_W(WORD_W)) u_chk (
  .clk(clk), .rst(rst), .latch_rise(latch_rise), .bit_cnt(bit_cnt),
  .vol_left_o(vol_left_o), .vol_right_o(vol_right_o), .ctrl_o(ctrl_o),
  .wr_left_o(wr_left_o), .wr_right_o(wr_right_o), .wr_ctrl_o(wr_ctrl_o)
);

// File: tb/tb_serial_ctrl_port.sv
module tb_serial_ctrl_port;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 10;
  localparam logic [15:0] VEC [NVEC] = '{
    16'hABCC, 16'h1236, 16'hFFFD, 16'h0003, 16'h0000,
    16'hFFFE, 16'h5555, 16'hFFFF, 16'h8002, 16'h7FFC
  };

  logic clk = 0, rst = 1;
  logic sclk = 0, sdat = 0, slat = 0;
  logic [13:0] vl, vr, vc;
  logic wl, wr_r, wc;
  int errors = 0, checks = 0;
  int nl = 0, nr = 0, nc = 0;
  logic [13:0] el = 0, er = 0, ec = 0;
  int xl = 0, xr = 0, xc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  serial_ctrl_port dut (
    .clk(clk), .rst(rst), .ser_clk_i(sclk), .ser_data_i(sdat), .ser_latch_i(slat),
    .vol_left_o(vl), .vol_right_o(vr), .ctrl_o(vc),
    .wr_left_o(wl), .wr_right_o(wr_r), .wr_ctrl_o(wc)
  );

  always @(negedge clk) if (!rst) begin
    nl += int'(wl); nr += int'(wr_r); nc += int'(wc);
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send_bits(input logic [31:0] w, input int n);
    for (int i = n - 1; i >= 0; i--) begin
      sdat = w[i];
      repeat (3) @(negedge clk);
      sclk = 1;
      repeat (4) @(negedge clk);
      sclk = 0;
      repeat (2) @(negedge clk);
    end
  endtask

  task automatic latch();
    slat = 1;
    repeat (4) @(negedge clk);
    slat = 0;
    repeat (6) @(negedge clk);
  endtask

  task automatic model(input logic [15:0] w);
    case (w[1:0])
      2'b00: begin el = w[15:2]; xl++; end
      2'b10: begin er = w[15:2]; xr++; end
      2'b01: begin ec = w[15:2]; xc++; end
      default: ;
    endcase
  endtask

  task automatic check_all(input string req);
    check({req, " left"},  {18'b0, vl}, {18'b0, el});
    check({req, " right"}, {18'b0, vr}, {18'b0, er});
    check({req, " ctrl"},  {18'b0, vc}, {18'b0, ec});
    check({req, " strobes"}, {nl[7:0], nr[7:0], nc[7:0]}, {xl[7:0], xr[7:0], xc[7:0]});
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    check_all("R10 reset");
    rst = 0;
    repeat (3) @(negedge clk);
    check_all("R10 after reset");

    for (int v = 0; v < NVEC; v++) begin
      send_bits({16'b0, VEC[v]}, 16);
      latch();
      model(VEC[v]);
      case (VEC[v][1:0])
        2'b00: check_all("R2 R1 R9 vector");
        2'b10: check_all("R3 R1 R9 vector");
        2'b01: check_all("R4 R1 R9 vector");
        default: check_all("R5 vector");
      endcase
    end

    // R6: complete word, no latch yet
    send_bits({16'b0, 16'h2468}, 16);
    repeat (10) @(negedge clk);
    check_all("R6 before latch");
    latch();
    model(16'h2468);
    check_all("R6 after latch");

    // R7: 15 bits, then 17 bits, then none
    send_bits({16'b0, 16'h1110}, 15);
    latch();
    check_all("R7 short frame");
    send_bits({15'b0, 17'h1FFF8}, 17);
    latch();
    check_all("R7 long frame");
    latch();
    check_all("R7 empty frame");

    // R8: good frame after a dropped one
    send_bits({16'b0, 16'h0BAD}, 9);
    latch();
    send_bits({16'b0, 16'hC0DE}, 16);
    latch();
    model(16'hC0DE);
    check_all("R8 recovery");

    // R10: reset mid-state
    rst = 1;
    repeat (3) @(negedge clk);
    el = 0; er = 0; ec = 0;
    check({"R10 left"}, {18'b0, vl}, 32'h0);
    check({"R10 right"}, {18'b0, vr}, 32'h0);
    check({"R10 ctrl"}, {18'b0, vc}, 32'h0);
    check({"R10 strobes"}, {29'b0, wl, wr_r, wc}, 32'h0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule